// File: doc/BRIEF.md
# Fan Blast Control with Serial-Access Watchdog

This block sits between the register file of a dual-fan controller and its two speed DACs. In normal operation it passes the two programmed 8-bit DAC codes straight through. When a blast happens, it overrides both codes with full scale (255) so that both fans run at maximum speed. The block also gathers every fault source into one active-low, open-drain style fault output.

A blast has three causes. The blast pin may be high when power-on reset is released. The blast pin may fall from high to low at any later time. The serial-access watchdog may expire. The watchdog counts reference-clock cycles only while the blast pin is high. It restarts whenever the device is addressed on the serial bus. If no access arrives within the programmed window, about 90 seconds, it forces a blast and records a timer fault. A write to the fault register ends the blast and clears both fault bits. The data byte of that write is never used.

All ports are plain control and status levels. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `fan_blast_ctrl`

## Requirements
- R1: After power-on reset is released with the blast pin low, blast_flt and timer_flt read 0, fault_n reads 1 when every external fault bit is 0, and each DAC output equals its programmed code.
- R2: If the blast pin is high when reset is released, blast_flt becomes 1 at the third rising clock edge after release, and both DAC outputs read 255 from then on.
- R3: A high-to-low change on the blast pin sets blast_flt at the third rising clock edge after the change. A low-to-high change never causes a blast.
- R4: While blast_flt is 1, both DAC outputs read 255 whatever code is programmed. While it is 0, each output follows its programmed code in the same cycle.
- R5: With the blast pin held high and no bus access, timer_flt and blast_flt both become 1 at rising edge TIMEOUT+2, counted from the pin's rise, and not earlier.
- R6: A one-cycle bus_addressed pulse sampled at edge k restarts the watchdog, so the timeout flags appear at edge k+TIMEOUT and not earlier.
- R7: While the blast pin is low the watchdog count is held at zero, so after the pin rises again a full TIMEOUT+2 edges pass before a timer fault.
- R8: A fault_wr pulse clears blast_flt and timer_flt at the next rising edge, and the DAC outputs return to the programmed codes. Without fault_wr and without reset, both flags hold their value.
- R9: When a blast event and fault_wr fall in the same cycle, the event wins: the flag it sets reads 1 after that edge.
- R10: fault_n is 0 whenever rst_n is 0, whenever blast_flt or timer_flt is 1, or whenever any bit of ext_flt is 1. This last case takes effect in the same cycle. Otherwise fault_n is 1.
- R11: After the watchdog expires it restarts by itself, so with the pin still high and no access, a second timer fault appears TIMEOUT edges after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the watchdog count |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| blast_in | input | 1 | Asynchronous blast pin; its falling edge blasts, and its high level arms the watchdog |
| bus_addressed | input | 1 | One-cycle pulse when the device is addressed on the serial bus |
| fault_wr | input | 1 | One-cycle pulse when the fault register is written |
| dac_code_a | input | DAC_W | Programmed code for DAC A |
| dac_code_b | input | DAC_W | Programmed code for DAC B |
| ext_flt | input | EXT_W | Fault bits from tach and GPIO logic elsewhere |
| dac_out_a | output | DAC_W | Effective code for DAC A |
| dac_out_b | output | DAC_W | Effective code for DAC B |
| blast_flt | output | 1 | Blast fault bit; 1 while a blast is in force |
| timer_flt | output | 1 | Watchdog timeout fault bit |
| fault_n | output | 1 | Active-low merged fault output |

## Verification
A blast or watchdog event can land in the same clock cycle as a fault-register write, which would set and clear the same flag at once. The bench provokes this case on purpose. It counts edges from a blast pin fall, and separately from a watchdog start, so that fault_wr is sampled exactly on the edge that latches the event. The case is judged correct only if the flag reads 1 afterwards, and the same check is repeated one cycle off the collision to show that the write does clear the flag when nothing competes with it.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  // Causes of a blast raised in one cycle
  typedef struct packed {
    logic pwr_up;    // pin high when reset released
    logic pin_fall;  // synchronized pin fell
    logic wd_exp;    // serial-access watchdog expired
  } blast_evt_t;

  function automatic logic evt_any(input blast_evt_t e);
    return e.pwr_up | e.pin_fall | e.wd_exp;
  endfunction

endpackage

// File: rtl/fbc_pin_sync.sv
module fbc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall,
  output logic pwr_up
);
  localparam int SW = $clog2(STAGES + 1);
  localparam logic [SW-1:0] SETTLE_END = SW'(STAGES);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic [SW-1:0]     settle;
  logic              pend;
  logic              settled;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign lvl     = chain[STAGES-1];
  assign settled = (settle == SETTLE_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      settle <= '0;
      pend   <= 1'b1;
    end else begin
      prev <= lvl;
      if (!settled) settle <= settle + 1'b1;
      if (pend && settled) pend <= 1'b0;
    end
  end

  // Sample the pin once, as soon as the chain carries its post-reset value
  assign pwr_up = pend & settled & lvl;
  assign fall   = prev & ~lvl;

endmodule

// File: rtl/fbc_watchdog.sv
module fbc_watchdog #(
  parameter int TIMEOUT = 4_500_000,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          kick,
  output logic          expire,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  assign expire = run & ~kick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || kick || expire) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fbc_fault_reg.sv
module fbc_fault_reg
  import fbc_pkg::*;
#(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  blast_evt_t       evt,
  input  logic             clr,
  input  logic [EXT_W-1:0] ext_flt,
  output logic             blast_flt,
  output logic             timer_flt,
  output logic             fault_n
);
  // A new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blast_flt <= 1'b0;
      timer_flt <= 1'b0;
    end else begin
      if (evt_any(evt)) blast_flt <= 1'b1;
      else if (clr)     blast_flt <= 1'b0;
      if (evt.wd_exp)   timer_flt <= 1'b1;
      else if (clr)     timer_flt <= 1'b0;
    end
  end

  assign fault_n = rst_n & ~(blast_flt | timer_flt | (|ext_flt));

endmodule

// File: rtl/fan_blast_ctrl.sv
module fan_blast_ctrl
  import fbc_pkg::*;
#(
  parameter int DAC_W       = 8,
  parameter int EXT_W       = 4,
  parameter int TIMEOUT     = 4_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blast_in,
  input  logic             bus_addressed,
  input  logic             fault_wr,
  input  logic [DAC_W-1:0] dac_code_a,
  input  logic [DAC_W-1:0] dac_code_b,
  input  logic [EXT_W-1:0] ext_flt,
  output logic [DAC_W-1:0] dac_out_a,
  output logic [DAC_W-1:0] dac_out_b,
  output logic             blast_flt,
  output logic             timer_flt,
  output logic             fault_n
);
  localparam int NUM_CH = 2;
  localparam int CW     = $clog2(TIMEOUT + 1);
  localparam logic [DAC_W-1:0] FULL = '1;

  logic          pin_lvl;
  logic          pin_fall;
  logic          pin_pwr_up;
  logic          wd_expire;
  logic [CW-1:0] wd_cnt;
  blast_evt_t    evt;

  fbc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (blast_in),
    .lvl    (pin_lvl),
    .fall   (pin_fall),
    .pwr_up (pin_pwr_up)
  );

  fbc_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (pin_lvl),
    .kick   (bus_addressed),
    .expire (wd_expire),
    .cnt    (wd_cnt)
  );

  assign evt.pwr_up   = pin_pwr_up;
  assign evt.pin_fall = pin_fall;
  assign evt.wd_exp   = wd_expire;

  fbc_fault_reg #(.EXT_W(EXT_W)) u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .clr       (fault_wr),
    .ext_flt   (ext_flt),
    .blast_flt (blast_flt),
    .timer_flt (timer_flt),
    .fault_n   (fault_n)
  );

  logic [DAC_W-1:0] code_in [NUM_CH];
  logic [DAC_W-1:0] code_eff[NUM_CH];

  assign code_in[0] = dac_code_a;
  assign code_in[1] = dac_code_b;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign code_eff[ch] = blast_flt ? FULL : code_in[ch];
  end

  assign dac_out_a = code_eff[0];
  assign dac_out_b = code_eff[1];

endmodule

// File: rtl/fbc_chk.sv
module fbc_chk #(
  parameter int DAC_W   = 8,
  parameter int EXT_W   = 4,
  parameter int TIMEOUT = 4_500_000,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_lvl,
  input logic [CW-1:0]    wd_cnt,
  input logic             fault_wr,
  input logic [EXT_W-1:0] ext_flt,
  input logic [DAC_W-1:0] dac_out_a,
  input logic [DAC_W-1:0] dac_out_b,
  input logic             blast_flt,
  input logic             timer_flt,
  input logic             fault_n
);
  localparam logic [CW-1:0]    LIM  = CW'(TIMEOUT);
  localparam logic [DAC_W-1:0] FULL = '1;

  // R3
  fall_blasts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_lvl) |=> blast_flt);

  // R4
  forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blast_flt |-> (dac_out_a == FULL && dac_out_b == FULL));

  // R5
  timer_blasts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_flt |-> blast_flt);

  // R5
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < LIM);

  // R7
  wd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_lvl |=> wd_cnt == '0);

  // R8
  blast_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blast_flt && !fault_wr) |=> blast_flt);

  // R10
  flag_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blast_flt || timer_flt || (|ext_flt)) |-> !fault_n);

endmodule

bind fan_blast_ctrl fbc_chk #(
  .DAC_W   (DAC_W),
  .EXT_W   (EXT_W),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_lvl   (pin_lvl),
  .wd_cnt    (wd_cnt),
  .fault_wr  (fault_wr),
  .ext_flt   (ext_flt),
  .dac_out_a (dac_out_a),
  .dac_out_b (dac_out_b),
  .blast_flt (blast_flt),
  .timer_flt (timer_flt),
  .fault_n   (fault_n)
);

// File: tb/fan_blast_ctrl_tb.sv
`timescale 1ns/1ps
module fan_blast_ctrl_tb;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blast_in = 1'b0;
  logic       bus_addressed = 1'b0;
  logic       fault_wr = 1'b0;
  logic [7:0] code_a = 8'h3C;
  logic [7:0] code_b = 8'hA5;
  logic [3:0] ext_flt = 4'h0;
  logic [7:0] out_a, out_b;
  logic       blast_flt, timer_flt, fault_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fan_blast_ctrl #(.TIMEOUT(TO)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .blast_in      (blast_in),
    .bus_addressed (bus_addressed),
    .fault_wr      (fault_wr),
    .dac_code_a    (code_a),
    .dac_code_b    (code_b),
    .ext_flt       (ext_flt),
    .dac_out_a     (out_a),
    .dac_out_b     (out_b),
    .blast_flt     (blast_flt),
    .timer_flt     (timer_flt),
    .fault_n       (fault_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n    = 1'b0;
    blast_in = pin;
    fault_wr = 1'b0;
    bus_addressed = 1'b0;
    step(3);
    chk("R10 fault_n during reset", fault_n, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clear();
    fault_wr = 1'b1;
    step(1);
    fault_wr = 1'b0;
  endtask

  task automatic t_reset();
    code_a = 8'h3C; code_b = 8'hA5;
    do_reset(1'b0);
    step(5);
    chk("R1 blast_flt", blast_flt, 1'b0);
    chk("R1 timer_flt", timer_flt, 1'b0);
    chk("R1 fault_n", fault_n, 1'b1);
    chk("R1 out_a", out_a, 8'h3C);
    chk("R1 out_b", out_b, 8'hA5);
  endtask

  task automatic t_powerup();
    do_reset(1'b1);
    step(2);
    chk("R2 not before edge 3", blast_flt, 1'b0);
    step(1);
    chk("R2 blast at edge 3", blast_flt, 1'b1);
    chk("R2 out_a full", out_a, 8'hFF);
    chk("R2 out_b full", out_b, 8'hFF);
    chk("R10 fault_n on blast", fault_n, 1'b0);
    pulse_clear();
    chk("R8 blast cleared", blast_flt, 1'b0);
    chk("R8 out_a restored", out_a, 8'h3C);
    chk("R8 fault_n released", fault_n, 1'b1);
    blast_in = 1'b0;
    step(3);
    pulse_clear();
  endtask

  task automatic t_fall();
    do_reset(1'b0);
    step(3);
    blast_in = 1'b1;
    step(4);
    chk("R3 rise no blast", blast_flt, 1'b0);
    blast_in = 1'b0;
    step(2);
    chk("R3 not before edge 3", blast_flt, 1'b0);
    step(1);
    chk("R3 blast on fall", blast_flt, 1'b1);
    code_a = 8'h11;
    #1;
    chk("R4 forced despite new code", out_a, 8'hFF);
    step(4);
    chk("R8 flag holds without clear", blast_flt, 1'b1);
    pulse_clear();
    chk("R4 out_a follows code", out_a, 8'h11);
    code_b = 8'h07;
    #1;
    chk("R4 out_b same cycle", out_b, 8'h07);
  endtask

  task automatic t_watchdog();
    do_reset(1'b0);
    step(3);
    blast_in = 1'b1;
    step(TO + 1);
    chk("R5 no timeout early", timer_flt, 1'b0);
    chk("R5 no blast early", blast_flt, 1'b0);
    step(1);
    chk("R5 timer_flt set", timer_flt, 1'b1);
    chk("R5 blast_flt set", blast_flt, 1'b1);
    chk("R5 out_b full", out_b, 8'hFF);
    pulse_clear();
    chk("R8 timer cleared", timer_flt, 1'b0);
    step(TO - 2);
    chk("R11 no second timeout early", timer_flt, 1'b0);
    step(1);
    chk("R11 second timeout", timer_flt, 1'b1);
    blast_in = 1'b0;
    step(3);
    pulse_clear();
  endtask

  task automatic t_kick();
    do_reset(1'b0);
    step(3);
    blast_in = 1'b1;
    step(20);
    bus_addressed = 1'b1;
    step(1);
    bus_addressed = 1'b0;
    step(TO - 1);
    chk("R6 kick delays timeout", timer_flt, 1'b0);
    step(1);
    chk("R6 timeout after kick", timer_flt, 1'b1);
    blast_in = 1'b0;
    step(3);
    pulse_clear();
  endtask

  task automatic t_gate();
    do_reset(1'b0);
    step(3);
    blast_in = 1'b1;
    step(30);
    blast_in = 1'b0;
    step(3);
    chk("R7 fall blasts, no timer", timer_flt, 1'b0);
    pulse_clear();
    step(5);
    blast_in = 1'b1;
    step(TO + 1);
    chk("R7 count restarted from zero", timer_flt, 1'b0);
    step(1);
    chk("R7 full window then timeout", timer_flt, 1'b1);
    blast_in = 1'b0;
    step(3);
    pulse_clear();
  endtask

  task automatic t_collide();
    do_reset(1'b0);
    step(3);
    blast_in = 1'b1;
    step(3);
    blast_in = 1'b0;
    step(2);
    fault_wr = 1'b1;
    step(1);
    fault_wr = 1'b0;
    chk("R9 fall beats clear", blast_flt, 1'b1);
    pulse_clear();
    chk("R9 later clear works", blast_flt, 1'b0);
    blast_in = 1'b1;
    step(TO + 1);
    fault_wr = 1'b1;
    step(1);
    fault_wr = 1'b0;
    chk("R9 timeout beats clear", timer_flt, 1'b1);
    blast_in = 1'b0;
    step(3);
    pulse_clear();
    chk("R8 all clear", timer_flt | blast_flt, 1'b0);
  endtask

  task automatic t_ext();
    do_reset(1'b0);
    step(4);
    for (int i = 0; i < 4; i++) begin
      ext_flt = 4'(1 << i);
      #1;
      chk("R10 ext bit pulls fault_n", fault_n, 1'b0);
      step(1);
    end
    ext_flt = 4'h0;
    #1;
    chk("R10 fault_n released", fault_n, 1'b1);
    chk("R10 flags untouched by ext", blast_flt | timer_flt, 1'b0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_fall();
    t_watchdog();
    t_kick();
    t_gate();
    t_collide();
    t_ext();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule